// File: doc/BRIEF.md
# Serial Command Register Interface

This block is the host-facing command port of a tone signalling device. A host controller frames each transaction with an active-low chip select and clocks bytes in MSB first on the rising edge of a serial clock. The first byte of every frame is an operation code. Some codes carry one or two data bytes that load configuration registers. Others return a status byte or a 16-bit measured-frequency word on a reply line that is only driven while reply bits are being shifted out. A single operation code returns every register and status flag to zero.

Three event inputs set sticky status flags: measurement done, quiet-period expired and interval tick expired. The flags are set whatever the enables say. Reading status returns the flags and clears them in the same step, and it releases the active-low interrupt at once. The interrupt is brought out as an open-drain pull-down enable. The configuration registers, the tone-word decodes and one-cycle load strobes go to the timers and tone paths that sit outside this block.

The serial pins are sampled in the system clock domain, so the system clock must run at least four times faster than the serial clock.

Top module: `serial_cmd_port`

## Requirements
- R1: The first byte after `csN` falls is an operation code. Bytes are shifted MSB first, and a bit is taken on each rising edge of `sclk` while `csN` is low.
- R2: Code 01h clears `modeReg`, `quietReg`, `tickReg`, `toneAReg`, `toneBReg` and all three status flags, and pulses `genResetOut` for one cycle.
- R3: Code 30h followed by one byte loads `modeReg` with that byte, with bits 1:0 forced to 0.
- R4: Code 33h followed by one byte loads `quietReg` and pulses `quietLoad`. Code 36h followed by one byte loads `tickReg` and pulses `tickLoad`.
- R5: Code 34h (tone A) or 35h (tone B) is followed by two bytes: bits 15:8 come first, then bits 7:0. The 16-bit word is committed only when the second byte completes. A frame aborted after the first byte leaves the register unchanged.
- R6: `toneAOff` and `toneBOff` are 1 exactly when bits 12:0 of the matching tone register are zero.
- R7: Code 31h returns one reply byte, MSB first: bits 7:4 are 0, bit 3 is the live `logicIn`, bit 2 is tick expired, bit 1 is quiet expired and bit 0 is measurement done. `replyOe` is 1 only while reply bits are pending and `csN` is low, and `replyOut` is 0 whenever `replyOe` is 0.
- R8: Recognising code 31h clears all status flags. A flag event that arrives in that same cycle is kept and shows on the next read.
- R9: Code 32h returns `freqWord` as two reply bytes, MSB first. The word is captured when the code byte completes and later changes to `freqWord` do not affect it. `freqTaken` pulses once per read.
- R10: `irqOe` is 1 when (measurement done or quiet expired) is set with `modeReg` bit 5 = 1, or when tick expired is set with `modeReg` bit 6 = 1. It is 0 from the cycle in which code 31h is recognised.
- R11: Status flags are set by their event inputs whatever the value of `modeReg` bits 6:5.
- R12: Raising `csN` aborts any transfer. An unknown code is ignored. After a command's payload or reply is complete, the next byte in the same frame is a new operation code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select that frames a transaction |
| sclk | input | 1 | Serial clock from the host |
| cmdIn | input | 1 | Serial command and data input |
| replyOut | output | 1 | Serial reply data |
| replyOe | output | 1 | Reply driver enable; the line is high impedance when 0 |
| irqOe | output | 1 | Open-drain pull-down enable for the active-low interrupt |
| logicIn | input | 1 | General-purpose level reported live in status bit 3 |
| measDone | input | 1 | Pulse: frequency measurement complete |
| quietExpired | input | 1 | Pulse: quiet period expired |
| tickExpired | input | 1 | Pulse: interval timer expired |
| freqWord | input | 16 | Measured frequency word from the counter |
| freqTaken | output | 1 | One-cycle pulse when the frequency word is captured for reply |
| modeReg | output | 8 | Mode register: switches, interrupt enables, band |
| quietReg | output | 8 | Quiet-period setting |
| tickReg | output | 8 | Interval timer setting |
| toneAReg | output | 16 | Tone generator A word |
| toneBReg | output | 16 | Tone generator B word |
| toneAOff | output | 1 | Tone A frequency field is zero (powersave) |
| toneBOff | output | 1 | Tone B frequency field is zero (powersave) |
| quietLoad | output | 1 | Pulse: quiet register written |
| tickLoad | output | 1 | Pulse: tick register written |
| genResetOut | output | 1 | Pulse: general reset executed |

## Verification
On every cycle, the assertions check that status flags stay set until a read or a reset, that a status read leaves only the same-cycle events set, and that the interrupt is released in the cycle the read code is recognised. They also check that a general reset zeroes every register, that at most one command strobe fires per cycle, and that the reply driver turns off after its last bit. Only the bench scenarios can show that serial bytes land in the right register fields, that the reply bits carry the right values in order, that an aborted two-byte write leaves its register unchanged, that the frequency word stays coherent while the counter moves on, and that several commands can run back to back in one frame.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int FLAG_N = 3;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam int LEFT_W = $clog2(WORD_W) + 1;

  localparam logic [BYTE_W-1:0] OP_RESET      = 8'h01;
  localparam logic [BYTE_W-1:0] OP_SET_MODE   = 8'h30;
  localparam logic [BYTE_W-1:0] OP_GET_STATUS = 8'h31;
  localparam logic [BYTE_W-1:0] OP_GET_FREQ   = 8'h32;
  localparam logic [BYTE_W-1:0] OP_SET_QUIET  = 8'h33;
  localparam logic [BYTE_W-1:0] OP_SET_TONE_A = 8'h34;
  localparam logic [BYTE_W-1:0] OP_SET_TONE_B = 8'h35;
  localparam logic [BYTE_W-1:0] OP_SET_TICK   = 8'h36;

  typedef enum logic [1:0] {PH_CMD, PH_DATA, PH_REPLY} phase_e;

  typedef struct packed {
    logic              genRst;
    logic              wrMode;
    logic              wrQuiet;
    logic              wrToneA;
    logic              wrToneB;
    logic              wrTick;
    logic              rdStatus;
    logic              rdFreq;
    logic [BYTE_W-1:0] hiByte;
    logic [BYTE_W-1:0] loByte;
  } strobe_t;
endpackage

// File: rtl/scp_ctrl.sv
module scp_ctrl import scp_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              cmdIn,
  input  logic [BYTE_W-1:0] statusByte,
  input  logic [WORD_W-1:0] freqWord,
  output strobe_t           strb,
  output logic              replyOut,
  output logic              replyOe
);
  logic              sclkQ;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-2:0] shiftReg;
  phase_e            phase;
  logic [BYTE_W-1:0] curOp;
  logic [1:0]        bytesLeft;
  logic [BYTE_W-1:0] hiHold;
  logic [WORD_W-1:0] replyShift;
  logic [LEFT_W-1:0] replyLeft;
  logic              rise;
  logic              byteDone;
  logic [BYTE_W-1:0] newByte;

  function automatic logic [1:0] payloadLen(input logic [BYTE_W-1:0] op);
    case (op)
      OP_SET_MODE, OP_SET_QUIET, OP_SET_TICK: payloadLen = 2'd1;
      OP_SET_TONE_A, OP_SET_TONE_B:           payloadLen = 2'd2;
      default:                                payloadLen = 2'd0;
    endcase
  endfunction

  assign rise     = sclk & ~sclkQ & ~csN;
  assign byteDone = rise && (bitCnt == CNT_W'(BYTE_W - 1)) && (phase != PH_REPLY);
  assign newByte  = {shiftReg, cmdIn};
  assign replyOe  = (phase == PH_REPLY) && !csN;
  assign replyOut = replyOe & replyShift[WORD_W-1];

  always_comb begin
    strb        = '0;
    strb.hiByte = hiHold;
    strb.loByte = newByte;
    if (byteDone) begin
      if (phase == PH_CMD) begin
        case (newByte)
          OP_RESET:      strb.genRst   = 1'b1;
          OP_GET_STATUS: strb.rdStatus = 1'b1;
          OP_GET_FREQ:   strb.rdFreq   = 1'b1;
          default:       ;
        endcase
      end else if (bytesLeft == 2'd1) begin
        case (curOp)
          OP_SET_MODE:   strb.wrMode  = 1'b1;
          OP_SET_QUIET:  strb.wrQuiet = 1'b1;
          OP_SET_TICK:   strb.wrTick  = 1'b1;
          OP_SET_TONE_A: strb.wrToneA = 1'b1;
          OP_SET_TONE_B: strb.wrToneB = 1'b1;
          default:       ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ      <= 1'b0;
      bitCnt     <= '0;
      shiftReg   <= '0;
      phase      <= PH_CMD;
      curOp      <= '0;
      bytesLeft  <= '0;
      hiHold     <= '0;
      replyShift <= '0;
      replyLeft  <= '0;
    end else begin
      sclkQ <= sclk;
      if (csN) begin
        bitCnt    <= '0;
        phase     <= PH_CMD;
        bytesLeft <= '0;
        replyLeft <= '0;
      end else if (rise) begin
        if (phase == PH_REPLY) begin
          replyShift <= {replyShift[WORD_W-2:0], 1'b0};
          replyLeft  <= replyLeft - 1'b1;
          if (replyLeft == LEFT_W'(1)) phase <= PH_CMD;
        end else begin
          shiftReg <= newByte[BYTE_W-2:0];
          bitCnt   <= bitCnt + 1'b1;
          if (bitCnt == CNT_W'(BYTE_W - 1)) begin
            if (phase == PH_CMD) begin
              curOp <= newByte;
              if (newByte == OP_GET_STATUS) begin
                replyShift <= {statusByte, {BYTE_W{1'b0}}};
                replyLeft  <= LEFT_W'(BYTE_W);
                phase      <= PH_REPLY;
              end else if (newByte == OP_GET_FREQ) begin
                replyShift <= freqWord;
                replyLeft  <= LEFT_W'(WORD_W);
                phase      <= PH_REPLY;
              end else if (payloadLen(newByte) != 2'd0) begin
                bytesLeft <= payloadLen(newByte);
                phase     <= PH_DATA;
              end
            end else begin
              if (bytesLeft == 2'd2) hiHold <= newByte;
              bytesLeft <= bytesLeft - 1'b1;
              if (bytesLeft == 2'd1) phase <= PH_CMD;
            end
          end
        end
      end
    end
  end

  AST_REPLY_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_REPLY && rise && replyLeft == LEFT_W'(1)) |=> !replyOe); // R7
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.genRst, strb.wrMode, strb.wrQuiet, strb.wrToneA,
              strb.wrToneB, strb.wrTick, strb.rdStatus, strb.rdFreq})); // R12
  AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> (bitCnt == '0 && phase == PH_CMD)); // R12
endmodule

// File: rtl/scp_regs.sv
module scp_regs import scp_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              logicIn,
  input  logic              measDone,
  input  logic              quietExpired,
  input  logic              tickExpired,
  output logic [BYTE_W-1:0] statusByte,
  output logic              irqOe,
  output logic [BYTE_W-1:0] modeReg,
  output logic [BYTE_W-1:0] quietReg,
  output logic [BYTE_W-1:0] tickReg,
  output logic [WORD_W-1:0] toneAReg,
  output logic [WORD_W-1:0] toneBReg,
  output logic              toneAOff,
  output logic              toneBOff,
  output logic              quietLoad,
  output logic              tickLoad,
  output logic              freqTaken,
  output logic              genResetOut
);
  localparam int FREQ_BITS = 13;
  localparam int MODE_RSV  = 2;

  logic [FLAG_N-1:0] flags;
  logic [FLAG_N-1:0] setVec;

  assign setVec     = {tickExpired, quietExpired, measDone};
  assign statusByte = {{(BYTE_W-FLAG_N-1){1'b0}}, logicIn, flags};
  assign irqOe      = (((flags[0] | flags[1]) & modeReg[5]) | (flags[2] & modeReg[6]))
                      & ~strb.rdStatus;
  assign toneAOff   = (toneAReg[FREQ_BITS-1:0] == '0);
  assign toneBOff   = (toneBReg[FREQ_BITS-1:0] == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= '0;
      quietReg <= '0;
      tickReg  <= '0;
      toneAReg <= '0;
      toneBReg <= '0;
      flags    <= '0;
    end else if (strb.genRst) begin
      modeReg  <= '0;
      quietReg <= '0;
      tickReg  <= '0;
      toneAReg <= '0;
      toneBReg <= '0;
      flags    <= '0;
    end else begin
      if (strb.wrMode)  modeReg  <= {strb.loByte[BYTE_W-1:MODE_RSV], {MODE_RSV{1'b0}}};
      if (strb.wrQuiet) quietReg <= strb.loByte;
      if (strb.wrTick)  tickReg  <= strb.loByte;
      if (strb.wrToneA) toneAReg <= {strb.hiByte, strb.loByte};
      if (strb.wrToneB) toneBReg <= {strb.hiByte, strb.loByte};
      flags <= (flags & ~{FLAG_N{strb.rdStatus}}) | setVec;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quietLoad   <= 1'b0;
      tickLoad    <= 1'b0;
      freqTaken   <= 1'b0;
      genResetOut <= 1'b0;
    end else begin
      quietLoad   <= strb.wrQuiet;
      tickLoad    <= strb.wrTick;
      freqTaken   <= strb.rdFreq;
      genResetOut <= strb.genRst;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.rdStatus && !strb.genRst) |=> ((flags & $past(flags)) == $past(flags))); // R11
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdStatus && !strb.genRst) |=> (flags == $past(setVec))); // R8
  AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdStatus |-> !irqOe); // R10
  AST_GEN_RESET: assert property (@(posedge clk) disable iff (!rstN)
    strb.genRst |=> (modeReg == '0 && quietReg == '0 && tickReg == '0 &&
                     toneAReg == '0 && toneBReg == '0 && flags == '0 && genResetOut)); // R2
endmodule

// File: rtl/serial_cmd_port.sv
module serial_cmd_port import scp_pkg::*; (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        sclk,
  input  logic        cmdIn,
  output logic        replyOut,
  output logic        replyOe,
  output logic        irqOe,
  input  logic        logicIn,
  input  logic        measDone,
  input  logic        quietExpired,
  input  logic        tickExpired,
  input  logic [15:0] freqWord,
  output logic        freqTaken,
  output logic [7:0]  modeReg,
  output logic [7:0]  quietReg,
  output logic [7:0]  tickReg,
  output logic [15:0] toneAReg,
  output logic [15:0] toneBReg,
  output logic        toneAOff,
  output logic        toneBOff,
  output logic        quietLoad,
  output logic        tickLoad,
  output logic        genResetOut
);
  strobe_t           strb;
  logic [BYTE_W-1:0] statusByte;

  scp_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .cmdIn(cmdIn),
    .statusByte(statusByte), .freqWord(freqWord), .strb(strb),
    .replyOut(replyOut), .replyOe(replyOe)
  );

  scp_regs regs_i (
    .clk(clk), .rstN(rstN), .strb(strb), .logicIn(logicIn),
    .measDone(measDone), .quietExpired(quietExpired), .tickExpired(tickExpired),
    .statusByte(statusByte), .irqOe(irqOe), .modeReg(modeReg),
    .quietReg(quietReg), .tickReg(tickReg), .toneAReg(toneAReg),
    .toneBReg(toneBReg), .toneAOff(toneAOff), .toneBOff(toneBOff),
    .quietLoad(quietLoad), .tickLoad(tickLoad), .freqTaken(freqTaken),
    .genResetOut(genResetOut)
  );
endmodule

// File: tb/serial_cmd_port_tb.sv
module serial_cmd_port_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, cmdIn = 1'b0;
  logic logicIn = 1'b0, measDone = 1'b0, quietExpired = 1'b0, tickExpired = 1'b0;
  logic [15:0] freqWord = 16'h0000;
  logic replyOut, replyOe, irqOe, freqTaken, toneAOff, toneBOff;
  logic quietLoad, tickLoad, genResetOut;
  logic [7:0] modeReg, quietReg, tickReg;
  logic [15:0] toneAReg, toneBReg;

  int total = 0;
  int bad = 0;
  int nQuiet = 0, nTick = 0, nFreq = 0, nReset = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serial_cmd_port dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .cmdIn(cmdIn),
    .replyOut(replyOut), .replyOe(replyOe), .irqOe(irqOe), .logicIn(logicIn),
    .measDone(measDone), .quietExpired(quietExpired), .tickExpired(tickExpired),
    .freqWord(freqWord), .freqTaken(freqTaken), .modeReg(modeReg),
    .quietReg(quietReg), .tickReg(tickReg), .toneAReg(toneAReg),
    .toneBReg(toneBReg), .toneAOff(toneAOff), .toneBOff(toneBOff),
    .quietLoad(quietLoad), .tickLoad(tickLoad), .genResetOut(genResetOut)
  );

  always @(posedge clk) begin
    if (quietLoad)   nQuiet++;
    if (tickLoad)    nTick++;
    if (freqTaken)   nFreq++;
    if (genResetOut) nReset++;
  end

  // {op, payload byte count, payload, expected register value}
  localparam logic [47:0] VEC [7] = '{
    {8'h30, 8'd1, 16'h00A7, 16'h00A4},
    {8'h30, 8'd1, 16'h00FF, 16'h00FC},
    {8'h33, 8'd1, 16'h0005, 16'h0005},
    {8'h36, 8'd1, 16'h000C, 16'h000C},
    {8'h34, 8'd2, 16'h1234, 16'h1234},
    {8'h35, 8'd2, 16'h5ABC, 16'h5ABC},
    {8'h35, 8'd2, 16'h4000, 16'h4000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic csLow();
    @(negedge clk); csN = 1'b0; sclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic csHigh();
    @(negedge clk); csN = 1'b1; sclk = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  // one byte MSB first; flag pulses land in the cycle the last bit is taken
  task automatic xfer(input logic [7:0] tx, input logic [2:0] pulse,
                      output logic [7:0] rx, output logic oeAll);
    oeAll = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0; cmdIn = tx[i];
      @(negedge clk);
      rx[i] = replyOut;
      oeAll = oeAll & replyOe;
      sclk = 1'b1;
      if (i == 0) {tickExpired, quietExpired, measDone} = pulse;
      @(negedge clk);
      {tickExpired, quietExpired, measDone} = 3'b000;
    end
    sclk = 1'b0;
  endtask

  task automatic pulseFlags(input logic [2:0] p);
    @(negedge clk); {tickExpired, quietExpired, measDone} = p;
    @(negedge clk); {tickExpired, quietExpired, measDone} = 3'b000;
    @(negedge clk);
  endtask

  task automatic writeFrame(input logic [7:0] op, input int n, input logic [15:0] pl);
    logic [7:0] rx;
    logic oe;
    csLow();
    xfer(op, 3'b000, rx, oe);
    if (n == 2) xfer(pl[15:8], 3'b000, rx, oe);
    if (n >= 1) xfer(pl[7:0], 3'b000, rx, oe);
    csHigh();
  endtask

  task automatic readStatus(input logic [2:0] pulse, output logic [7:0] val, output logic oe);
    logic [7:0] rx;
    logic oeCmd;
    csLow();
    xfer(8'h31, pulse, rx, oeCmd);
    xfer(8'h00, 3'b000, val, oe);
    csHigh();
  endtask

  initial begin
    logic [7:0] rx, hi, lo;
    logic oe;
    logic [15:0] obs;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    chk("R2 reset regs", {modeReg, quietReg, tickReg}, 32'h0);
    chk("R2 reset tones", {toneAReg, toneBReg}, 32'h0);
    chk("R7 reset oe", {replyOe, replyOut, irqOe}, 32'h0);

    // vector table of register writes (R1 R3 R4 R5)
    foreach (VEC[k]) begin
      writeFrame(VEC[k][47:40], int'(VEC[k][39:32]), VEC[k][31:16]);
      case (VEC[k][47:40])
        8'h30: obs = {8'h00, modeReg};
        8'h33: obs = {8'h00, quietReg};
        8'h36: obs = {8'h00, tickReg};
        8'h34: obs = toneAReg;
        default: obs = toneBReg;
      endcase
      chk($sformatf("R1 R3 R4 R5 vector %0d", k), obs, VEC[k][15:0]);
    end
    chk("R4 load strobes", {nQuiet[15:0], nTick[15:0]}, {16'd1, 16'd1});
    chk("R6 toneB off with bit14 only", toneBOff, 1'b1);
    chk("R6 toneA on", toneAOff, 1'b0);
    writeFrame(8'h34, 2, 16'h2000);
    chk("R6 toneA off with park bit", toneAOff, 1'b1);

    // R11: flags set with interrupts disabled
    writeFrame(8'h30, 1, 16'h0000);
    logicIn = 1'b1;
    pulseFlags(3'b101);
    chk("R11 irq stays off", irqOe, 1'b0);
    readStatus(3'b000, rx, oe);
    chk("R7 R11 status byte", rx, 8'h0D);
    chk("R7 oe during reply", oe, 1'b1);
    chk("R7 oe after frame", {replyOe, replyOut}, 2'b00);
    readStatus(3'b000, rx, oe);
    chk("R8 cleared after read", rx, 8'h08);

    // R10: interrupt enable and release
    writeFrame(8'h30, 1, 16'h0040);
    pulseFlags(3'b001);
    chk("R10 meas masked by bit5", irqOe, 1'b0);
    pulseFlags(3'b100);
    chk("R10 tick irq", irqOe, 1'b1);
    csLow();
    xfer(8'h31, 3'b000, rx, oe);
    chk("R10 release on read code", irqOe, 1'b0);
    xfer(8'h00, 3'b000, rx, oe);
    csHigh();
    chk("R7 tick and meas status", rx, 8'h0D);
    writeFrame(8'h30, 1, 16'h0020);
    pulseFlags(3'b010);
    chk("R10 quiet irq", irqOe, 1'b1);
    readStatus(3'b000, rx, oe);
    chk("R7 quiet status", rx, 8'h0A);
    chk("R10 irq off after read", irqOe, 1'b0);

    // R8: event in the same cycle as the read is kept
    readStatus(3'b001, rx, oe);
    chk("R8 same-cycle not in reply", rx, 8'h08);
    chk("R10 kept flag raises irq", irqOe, 1'b1);
    readStatus(3'b000, rx, oe);
    chk("R8 same-cycle kept", rx, 8'h09);

    // R9: coherent frequency word
    freqWord = 16'hBEEF;
    csLow();
    xfer(8'h32, 3'b000, rx, oe);
    freqWord = 16'h1111;
    xfer(8'h00, 3'b000, hi, oe);
    xfer(8'h00, 3'b000, lo, oe);
    csHigh();
    chk("R9 frequency word", {hi, lo}, 16'hBEEF);
    chk("R9 freqTaken pulses", nFreq, 1);

    // R5 R12: abort mid write, partial reply
    csLow();
    xfer(8'h34, 3'b000, rx, oe);
    xfer(8'hAB, 3'b000, rx, oe);
    csHigh();
    chk("R5 aborted tone write", toneAReg, 16'h2000);
    csLow();
    xfer(8'h31, 3'b000, rx, oe);
    csHigh();
    chk("R12 abort reply oe", replyOe, 1'b0);
    writeFrame(8'h30, 1, 16'h0014);
    chk("R12 A/C after abort", modeReg, 8'h14);

    // R12: unknown code then streamed commands in one frame
    csLow();
    xfer(8'h77, 3'b000, rx, oe);
    xfer(8'h30, 3'b000, rx, oe);
    xfer(8'h48, 3'b000, rx, oe);
    xfer(8'h33, 3'b000, rx, oe);
    xfer(8'h21, 3'b000, rx, oe);
    csHigh();
    chk("R12 streamed mode", modeReg, 8'h48);
    chk("R12 streamed quiet", quietReg, 8'h21);

    // R2: general reset
    pulseFlags(3'b111);
    writeFrame(8'h01, 0, 16'h0000);
    chk("R2 regs cleared", {modeReg, quietReg, tickReg}, 32'h0);
    chk("R2 tones cleared", {toneAReg, toneBReg}, 32'h0);
    chk("R2 reset pulse", nReset, 1);
    readStatus(3'b000, rx, oe);
    chk("R2 flags cleared", rx, 8'h08);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule